// File: doc/BRIEF.md
# Legacy I/O Interrupt Register Hub

This block is the byte-wide register front end of a legacy PC-style I/O window. It holds the pending and enable state of a primary interrupt controller and drives one level-sensitive interrupt line upstream. That line is high whenever a pending bit is also enabled. Hardware sources set and clear pending bits through two side-band vectors. Software clears a single pending bit by writing its index to an acknowledge port.

The same window also reaches blocks that live outside this one. Accesses to the three timer counters and the timer control register go out on a single-cycle request port. The real-time-clock register file is reached by first loading an index register and then using a data port. A status port shows the speaker output of timer channel 2. The DMA, keyboard and secondary-controller ports accept writes and ignore them, except for the two DMA mode registers, which are driven out to the DMA engine.

Every access completes with a one-cycle response pulse a fixed number of cycles after it is accepted. An access at an unknown offset, in the wrong direction or of the wrong size completes with zero data and has no effect. It also sets a sticky error flag.

Top module: `legacy_io_hub`

## Requirements
- R1: A byte write to the primary mask port (offset 0x00) sets the enable mask to the complement of the written byte, so a written 1 disables that source. A read of the port returns the written byte.
- R2: `irq_out` is high exactly when the pending register AND the enable mask is nonzero. It follows mask writes, acknowledges, posts and clears.
- R3: A write to the primary acknowledge port (offset 0x04) clears pending bit n, where n is the low 4 bits of the data. Indices 8 to 15 change nothing.
- R4: Each cycle, `post_vec` bits are ORed into the pending register and `clr_vec` bits are removed from it. A clear wins over a post of the same bit in the same cycle.
- R5: A read of the primary status port (offset 0x02) returns the pending byte. This is the only port that also accepts a 64-bit read (`req_size`=1), which returns the pending byte zero-extended.
- R6: The secondary status port (0x03) always reads zero. A write to the secondary mask (0x01) stores the byte, and a read of that port returns its complement. Neither the secondary mask nor the secondary acknowledge (0x05) ever affects `irq_out` or the pending register.
- R7: A write to 0x10 loads the clock index. A read or write at 0x11 issues `rtc_req` with `rtc_index` equal to that index, and a read returns `rtc_rdata`.
- R8: Offsets 0x08 to 0x0A (counters 0 to 2, read or write) and 0x0B (control, write only) issue `tmr_req` with `tmr_sel` equal to the low two offset bits. A counter read returns `tmr_rdata`.
- R9: A read of port B (0x18) returns `SPKR_PAT` (default 0x20) when `tmr2_out` is high and 0 otherwise. Writes to port B are ignored.
- R10: Writes to 0x29 and 0x2A set `dma_mode_a` and `dma_mode_b`. Writes to the keyboard port and the DMA command, mask, master-mask and reset ports (0x20 to 0x28) change nothing.
- R11: An illegal access sets the sticky `err_flag` and completes with zero read data. An illegal access is any of: an unknown offset, a read of a write-only port, a write of a read-only port, or a 64-bit access other than the status read. It has no other effect.
- R12: `rsp_ready` pulses for exactly one cycle, `LATENCY` cycles after the accepting edge. Requests made while an access is in flight are ignored.
- R13: Reset clears the pending register, both masks, both mode registers, the clock index and `err_flag`, and drives `irq_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Port offset |
| req_size | input | 1 | 0 = byte, 1 = 64-bit |
| req_wdata | input | 8 | Write byte |
| rsp_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 64 | Read data, valid with rsp_ready |
| err_flag | output | 1 | Sticky illegal-access flag |
| irq_out | output | 1 | Aggregated interrupt level |
| post_vec | input | 8 | Pending bits to set |
| clr_vec | input | 8 | Pending bits to clear |
| tmr_req | output | 1 | Timer access strobe |
| tmr_we | output | 1 | Timer write enable |
| tmr_sel | output | 2 | Counter 0-2 or control (3) |
| tmr_wdata | output | 8 | Timer write byte |
| tmr_rdata | input | 8 | Timer read byte, same cycle |
| tmr2_out | input | 1 | Timer channel 2 output level |
| rtc_req | output | 1 | Clock register access strobe |
| rtc_we | output | 1 | Clock write enable |
| rtc_index | output | 8 | Selected clock register |
| rtc_wdata | output | 8 | Clock write byte |
| rtc_rdata | input | 8 | Clock read byte, same cycle |
| dma_mode_a | output | 8 | First DMA mode register |
| dma_mode_b | output | 8 | Second DMA mode register |

## Verification
The embedded assertions check properties that hold on every cycle:
- The stored mask is the complement of the written byte.
- Acknowledged and cleared bits are gone on the next cycle.
- Posted bits land unless a clear or acknowledge competes with them.
- The response pulse lasts one cycle, the error flag never falls, and an errored response carries zero data.

Only the bench scenarios can show the readback values through the register map, the level of `irq_out` under a changing mix of pending and enable, the forwarding to the timer and clock ports, and the ignored ports leaving the state untouched.

// File: rtl/legacy_io_hub.sv
module legacy_io_hub #(
  parameter int         LATENCY  = 2,
  parameter logic [7:0] SPKR_PAT = 8'h20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic        req_size,
  input  logic [7:0]  req_wdata,
  output logic        rsp_ready,
  output logic [63:0] rsp_rdata,
  output logic        err_flag,
  output logic        irq_out,
  input  logic [7:0]  post_vec,
  input  logic [7:0]  clr_vec,
  output logic        tmr_req,
  output logic        tmr_we,
  output logic [1:0]  tmr_sel,
  output logic [7:0]  tmr_wdata,
  input  logic [7:0]  tmr_rdata,
  input  logic        tmr2_out,
  output logic        rtc_req,
  output logic        rtc_we,
  output logic [7:0]  rtc_index,
  output logic [7:0]  rtc_wdata,
  input  logic [7:0]  rtc_rdata,
  output logic [7:0]  dma_mode_a,
  output logic [7:0]  dma_mode_b
);
  localparam logic [7:0] A_MASK1 = 8'h00, A_MASK2 = 8'h01, A_STAT1 = 8'h02, A_STAT2 = 8'h03;
  localparam logic [7:0] A_ACK1  = 8'h04, A_ACK2  = 8'h05;
  localparam logic [7:0] A_TMR0  = 8'h08, A_TMR1  = 8'h09, A_TMR2  = 8'h0A, A_TCTL  = 8'h0B;
  localparam logic [7:0] A_RIDX  = 8'h10, A_RDAT  = 8'h11, A_PORTB = 8'h18;
  localparam logic [7:0] A_KBD   = 8'h20, A_DCMD1 = 8'h21, A_DCMD2 = 8'h22, A_DMM1  = 8'h23;
  localparam logic [7:0] A_DMM2  = 8'h24, A_DRST1 = 8'h25, A_DRST2 = 8'h26, A_DMSK1 = 8'h27;
  localparam logic [7:0] A_DMSK2 = 8'h28, A_DMOD1 = 8'h29, A_DMOD2 = 8'h2A;
  localparam int CW = (LATENCY > 1) ? $clog2(LATENCY) : 1;

  logic          busy;
  logic [CW-1:0] cnt;
  logic [7:0]    pend, en, mask2_q, ridx;
  logic [63:0]   rdata_q;
  logic          resp_err;
  logic          rd_ok, wr_ok;
  logic [7:0]    rd_val;

  wire acc    = req_valid && !busy;
  wire legal  = req_write ? (wr_ok && !req_size)
                          : (rd_ok && (!req_size || req_addr == A_STAT1));
  wire go     = acc && legal;
  wire wr     = go && req_write;
  wire ack_hit = wr && req_addr == A_ACK1 && !req_wdata[3];
  wire [7:0] ack_mask = ack_hit ? (8'h01 << req_wdata[2:0]) : 8'h00;

  always_comb begin
    rd_ok  = 1'b1;
    rd_val = 8'h00;
    case (req_addr)
      A_MASK1:                rd_val = ~en;
      A_MASK2:                rd_val = ~mask2_q;
      A_STAT1:                rd_val = pend;
      A_STAT2:                rd_val = 8'h00;
      A_TMR0, A_TMR1, A_TMR2: rd_val = tmr_rdata;
      A_RDAT:                 rd_val = rtc_rdata;
      A_PORTB:                rd_val = tmr2_out ? SPKR_PAT : 8'h00;
      default:                rd_ok  = 1'b0;
    endcase
  end

  always_comb begin
    case (req_addr)
      A_MASK1, A_MASK2, A_ACK1, A_ACK2, A_TMR0, A_TMR1, A_TMR2, A_TCTL,
      A_RIDX, A_RDAT, A_PORTB, A_KBD, A_DCMD1, A_DCMD2, A_DMM1, A_DMM2,
      A_DRST1, A_DRST2, A_DMSK1, A_DMSK2, A_DMOD1, A_DMOD2: wr_ok = 1'b1;
      default:                                              wr_ok = 1'b0;
    endcase
  end

  assign tmr_req   = go && req_addr[7:2] == A_TMR0[7:2];
  assign tmr_we    = req_write;
  assign tmr_sel   = req_addr[1:0];
  assign tmr_wdata = req_wdata;
  assign rtc_req   = go && req_addr == A_RDAT;
  assign rtc_we    = req_write;
  assign rtc_index = ridx;
  assign rtc_wdata = req_wdata;

  assign irq_out   = |(pend & en);
  assign rsp_ready = busy && cnt == '0;
  assign rsp_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 8'h00;
      en         <= 8'h00;
      mask2_q    <= 8'h00;
      ridx       <= 8'h00;
      dma_mode_a <= 8'h00;
      dma_mode_b <= 8'h00;
      err_flag   <= 1'b0;
      busy       <= 1'b0;
      cnt        <= '0;
      rdata_q    <= '0;
      resp_err   <= 1'b0;
    end else begin
      pend <= (pend | post_vec) & ~clr_vec & ~ack_mask;
      if (wr) begin
        case (req_addr)
          A_MASK1: en         <= ~req_wdata;
          A_MASK2: mask2_q    <= req_wdata;
          A_RIDX:  ridx       <= req_wdata;
          A_DMOD1: dma_mode_a <= req_wdata;
          A_DMOD2: dma_mode_b <= req_wdata;
          default: ;
        endcase
      end
      if (acc) begin
        busy     <= 1'b1;
        cnt      <= CW'(LATENCY - 1);
        rdata_q  <= (go && !req_write) ? {56'h0, rd_val} : 64'h0;
        resp_err <= !legal;
        if (!legal) err_flag <= 1'b1;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  a_r1_mask_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && req_addr == A_MASK1) |=> (en == ~$past(req_wdata)));
  a_r3_ack_clears_index: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> !pend[$past(req_wdata[2:0])]);
  a_r4_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_vec) |=> ((pend & $past(clr_vec)) == 8'h00));
  a_r4_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((|post_vec) && clr_vec == 8'h00 && !ack_hit) |=> ((pend & $past(post_vec)) == $past(post_vec)));
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  a_r11_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ready && resp_err) |-> (rsp_rdata == 64'h0));
  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |=> !rsp_ready);
endmodule

// File: tb/legacy_io_hub_test.sv
module legacy_io_hub_test;
  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
  logic [7:0] req_addr = 8'h00, req_wdata = 8'h00;
  logic [7:0] post_vec = 8'h00, clr_vec = 8'h00;
  logic tmr2_out = 1'b0;
  logic rsp_ready, err_flag, irq_out, tmr_req, tmr_we, rtc_req, rtc_we;
  logic [63:0] rsp_rdata;
  logic [1:0] tmr_sel;
  logic [7:0] tmr_wdata, tmr_rdata, rtc_index, rtc_wdata, rtc_rdata, dma_mode_a, dma_mode_b;
  logic [7:0] rtc_mem [0:255];
  logic [1:0] tl_sel = 2'd0;
  logic [7:0] tl_dat = 8'h00;
  int n_chk = 0, n_err = 0, bad_pulse = 0, last_lat = 0;
  logic [63:0] rd;

  always #10 clk = ~clk;

  legacy_io_hub #(.LATENCY(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .err_flag(err_flag), .irq_out(irq_out),
    .post_vec(post_vec), .clr_vec(clr_vec), .tmr_req(tmr_req), .tmr_we(tmr_we),
    .tmr_sel(tmr_sel), .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata), .tmr2_out(tmr2_out),
    .rtc_req(rtc_req), .rtc_we(rtc_we), .rtc_index(rtc_index), .rtc_wdata(rtc_wdata),
    .rtc_rdata(rtc_rdata), .dma_mode_a(dma_mode_a), .dma_mode_b(dma_mode_b));

  assign tmr_rdata = 8'hA0 | {6'h0, tmr_sel};
  assign rtc_rdata = rtc_mem[rtc_index];
  always @(posedge clk) begin
    if (tmr_req && tmr_we) begin tl_sel <= tmr_sel; tl_dat <= tmr_wdata; end
    if (rtc_req && rtc_we) rtc_mem[rtc_index] <= rtc_wdata;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic [7:0] a, input logic sz,
                        input logic [7:0] d, output logic [63:0] r);
    int lat;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_ready && lat < 50) begin @(negedge clk); lat++; end
    r = rsp_rdata;
    last_lat = lat;
    @(negedge clk);
    if (rsp_ready) bad_pulse++;
  endtask

  task automatic side(input logic [7:0] p, input logic [7:0] c);
    @(negedge clk); post_vec = p; clr_vec = c;
    @(negedge clk); post_vec = 8'h00; clr_vec = 8'h00;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  // {write, addr, size, wdata, expected rdata}
  localparam logic [25:0] VEC [0:15] = '{
    {1'b1, 8'h00, 1'b0, 8'hFF, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00, 8'hFF},
    {1'b1, 8'h00, 1'b0, 8'hF0, 8'h00},
    {1'b0, 8'h00, 1'b0, 8'h00, 8'hF0},
    {1'b0, 8'h02, 1'b0, 8'h00, 8'h00},
    {1'b1, 8'h10, 1'b0, 8'h05, 8'h00},
    {1'b1, 8'h11, 1'b0, 8'h3C, 8'h00},
    {1'b0, 8'h11, 1'b0, 8'h00, 8'h3C},
    {1'b0, 8'h09, 1'b0, 8'h00, 8'hA1},
    {1'b0, 8'h0A, 1'b0, 8'h00, 8'hA2},
    {1'b1, 8'h01, 1'b0, 8'h12, 8'h00},
    {1'b0, 8'h01, 1'b0, 8'h00, 8'hED},
    {1'b0, 8'h03, 1'b0, 8'h00, 8'h00},
    {1'b1, 8'h29, 1'b0, 8'h55, 8'h00},
    {1'b1, 8'h20, 1'b0, 8'h77, 8'h00},
    {1'b0, 8'h18, 1'b0, 8'h00, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) rtc_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    check("R13 irq", irq_out, 1'b0);
    check("R13 err", err_flag, 1'b0);
    check("R13 ready", rsp_ready, 1'b0);
    check("R13 modes", {dma_mode_a, dma_mode_b}, 16'h0000);
    check("R13 rtc index", rtc_index, 8'h00);
    access(1'b0, 8'h00, 1'b0, 8'h00, rd); check("R13 mask readback", rd, 64'hFF);
    access(1'b0, 8'h02, 1'b0, 8'h00, rd); check("R13 pending", rd, 64'h00);

    // table walk: R1 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 16; i++) begin
      access(VEC[i][25], VEC[i][24:17], VEC[i][16], VEC[i][15:8], rd);
      check($sformatf("R1/R5-R10 vector %0d", i), rd, {56'h0, VEC[i][7:0]});
    end
    check("R10 mode a", dma_mode_a, 8'h55);
    check("R11 no error after legal table", err_flag, 1'b0);

    // R2 R4: masked post, then enabled post
    side(8'h10, 8'h00);
    check("R2 masked source low", irq_out, 1'b0);
    access(1'b0, 8'h02, 1'b0, 8'h00, rd); check("R5 status", rd, 64'h10);
    side(8'h01, 8'h00);
    check("R2 enabled source high", irq_out, 1'b1);
    // R3 acknowledge by index
    access(1'b1, 8'h04, 1'b0, 8'hF0, rd);
    check("R3 ack idx0 drops irq", irq_out, 1'b0);
    access(1'b0, 8'h02, 1'b0, 8'h00, rd); check("R3 ack idx0 status", rd, 64'h10);
    access(1'b1, 8'h04, 1'b0, 8'h09, rd);
    access(1'b0, 8'h02, 1'b0, 8'h00, rd); check("R3 idx 9 no effect", rd, 64'h10);
    // R1 R2 mask changes
    access(1'b1, 8'h00, 1'b0, 8'h00, rd); check("R1 unmask raises irq", irq_out, 1'b1);
    access(1'b1, 8'h00, 1'b0, 8'h10, rd); check("R1 mask bit4 drops irq", irq_out, 1'b0);
    // R4 clear, and clear beats post
    side(8'h00, 8'h10);
    access(1'b0, 8'h02, 1'b0, 8'h00, rd); check("R4 clear", rd, 64'h00);
    side(8'h04, 8'h04);
    access(1'b0, 8'h02, 1'b0, 8'h00, rd); check("R4 clear wins", rd, 64'h00);
    // R5 wide status read
    side(8'h83, 8'h00);
    access(1'b0, 8'h02, 1'b1, 8'h00, rd); check("R5 64-bit status", rd, 64'h83);
    check("R2 irq with 0x83 and en 0xEF", irq_out, 1'b1);
    // R6 secondary controller
    access(1'b1, 8'h00, 1'b0, 8'hFF, rd); check("R2 all masked", irq_out, 1'b0);
    access(1'b1, 8'h01, 1'b0, 8'h00, rd); check("R6 secondary mask no irq", irq_out, 1'b0);
    access(1'b1, 8'h05, 1'b0, 8'h01, rd);
    access(1'b0, 8'h02, 1'b0, 8'h00, rd); check("R6 secondary ack no effect", rd, 64'h83);
    access(1'b0, 8'h01, 1'b0, 8'h00, rd); check("R6 secondary mask readback", rd, 64'hFF);
    // R9 port B
    tmr2_out = 1'b1;
    access(1'b0, 8'h18, 1'b0, 8'h00, rd); check("R9 speaker high", rd, 64'h20);
    access(1'b1, 8'h18, 1'b0, 8'h00, rd);
    access(1'b0, 8'h18, 1'b0, 8'h00, rd); check("R9 write ignored", rd, 64'h20);
    tmr2_out = 1'b0;
    access(1'b0, 8'h18, 1'b0, 8'h00, rd); check("R9 speaker low", rd, 64'h00);
    // R8 timer forwarding
    access(1'b1, 8'h0B, 1'b0, 8'h36, rd); check("R8 control write", {tl_sel, tl_dat}, {2'd3, 8'h36});
    access(1'b1, 8'h08, 1'b0, 8'h12, rd); check("R8 counter0 write", {tl_sel, tl_dat}, {2'd0, 8'h12});
    access(1'b0, 8'h08, 1'b0, 8'h00, rd); check("R8 counter0 read", rd, 64'hA0);
    // R10 ignored ports and mode registers
    access(1'b1, 8'h2A, 1'b0, 8'h66, rd); check("R10 mode b", dma_mode_b, 8'h66);
    access(1'b1, 8'h27, 1'b0, 8'h01, rd);
    access(1'b1, 8'h25, 1'b0, 8'hAA, rd);
    access(1'b1, 8'h21, 1'b0, 8'h29, rd);
    check("R10 modes unchanged", {dma_mode_a, dma_mode_b}, 16'h5566);
    access(1'b0, 8'h02, 1'b0, 8'h00, rd); check("R10 pending unchanged", rd, 64'h83);
    check("R10 no error", err_flag, 1'b0);
    // R7 clock index/data
    access(1'b1, 8'h10, 1'b0, 8'h07, rd);
    access(1'b1, 8'h11, 1'b0, 8'h99, rd);
    access(1'b0, 8'h11, 1'b0, 8'h00, rd); check("R7 data at index 7", rd, 64'h99);
    access(1'b1, 8'h10, 1'b0, 8'h05, rd);
    access(1'b0, 8'h11, 1'b0, 8'h00, rd); check("R7 data at index 5", rd, 64'h3C);
    // R12 timing
    check("R12 latency", last_lat, LAT);
    check("R12 one-cycle pulse", bad_pulse, 0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_size = 1'b0; req_wdata = 8'h00;
    @(negedge clk);
    req_wdata = 8'hFF;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 6; k++) @(negedge clk);
    access(1'b0, 8'h00, 1'b0, 8'h00, rd); check("R12 busy request ignored", rd, 64'h00);
    // R11 illegal accesses
    access(1'b0, 8'h04, 1'b0, 8'h00, rd); check("R11 read write-only data", rd, 64'h00);
    check("R11 err set", err_flag, 1'b1);
    access(1'b0, 8'h00, 1'b1, 8'h00, rd); check("R11 wide mask read data", rd, 64'h00);
    access(1'b1, 8'h02, 1'b0, 8'h00, rd);
    access(1'b1, 8'hFF, 1'b0, 8'h00, rd);
    access(1'b1, 8'h00, 1'b1, 8'hFF, rd);
    access(1'b0, 8'h02, 1'b0, 8'h00, rd); check("R11 pending untouched", rd, 64'h83);
    access(1'b0, 8'h00, 1'b0, 8'h00, rd); check("R11 mask untouched", rd, 64'h00);
    check("R11 err sticky", err_flag, 1'b1);
    finish_run();
  end
endmodule